// File: doc/BRIEF.md
# H-Bridge Command Decoder with Standby

This block is the logic front end of a controller for two independent full bridges. Each bridge is commanded by a two-wire pair (A,B). The block turns each pair into four gate enables: high and low side of output leg 1 and of output leg 2. A current-trip flag that arrives during a drive command starts a mixed-decay chop sequence: fast decay, dead time, then slow decay. A per-bridge overcurrent flag sets a fault latch that turns that bridge fully off. The global undervoltage and over-temperature flags turn every bridge off for as long as they are present.

When every command input has been low for 1 ms, the block goes into a low-power standby state. Any input going high wakes it up. The block then holds all gates off for a wake-up delay of 200 µs so the gate supply can settle. Leaving standby is the only logic event, apart from reset, that clears the overcurrent latches. All asynchronous inputs pass through two-flop synchronisers. All times are counted in cycles of one clock whose rate is set by `CLK_KHZ`.

The standby sequencer has three states. SYS_RUN moves to SYS_SLEEP on "idle expired". SYS_SLEEP moves to SYS_WAKE on "input seen". SYS_WAKE moves to SYS_RUN on "hold expired". Each bridge sequencer has the states BR_OFF, BR_FWD, BR_REV, BR_BRAKE, BR_FAST, BR_DEAD and BR_SLOW. It has these transitions:
- "decode": from any static state to the state the command selects.
- "trip": from BR_FWD or BR_REV to BR_FAST.
- "fast done": from BR_FAST to BR_DEAD.
- "dead done": from BR_DEAD to BR_SLOW.
- "slow done": from BR_SLOW back to decode.
- "abort": a chop state sees a command other than the one being chopped and goes to decode.
- "kill": any state goes to BR_OFF while the bridge is faulted or globally disabled.

Top module: `hbridge_cmd_dec`

## Requirements
- R1: Pair (A,B)=(1,0) drives forward: leg 1 high side and leg 2 low side on, gate pattern {hi1,lo1,hi2,lo2}=1001. Pair (0,1) drives reverse, pattern 0110.
- R2: Pair (1,1) brakes with both low sides on, pattern 0101. Pair (0,0) coasts with all four gates off, pattern 0000.
- R3: A trip flag seen in forward or reverse starts the chop sequence. The sequence is TOFF/2 cycles of fast decay (the opposite diagonal), then DEAD cycles with all gates off, then TOFF-TOFF/2-DEAD cycles of slow decay (0101). After that the bridge returns to the drive state. TOFF is 25 µs and DEAD is 0.5 µs, each converted to clock cycles with a minimum of one cycle.
- R4: Standby is entered when all command inputs have been low for 1 ms (CLK_KHZ cycles), plus a few cycles of synchroniser latency. `standby_o` is 1 in standby.
- R5: Any command input going high before the idle time has expired restarts the idle timer.
- R6: Any high input in standby starts the wake-up. Every gate stays off for 200 µs (CLK_KHZ/5 cycles), and then the commands are decoded again.
- R7: An overcurrent flag sets that bridge's fault latch. The latch shows on its bit of `fault_o` and forces that bridge fully off. The other bridge is not affected.
- R8: A fault latch survives command changes and entry into standby. It clears only when standby is left or on reset.
- R9: Undervoltage or over-temperature sets `gdis_o` and holds every gate off. Neither one latches: decoding resumes once the flag clears.
- R10: The high and low side of the same leg are never on together.
- R11: After reset all gates are off, `fault_o` is 0 and `standby_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_a_i | input | NB | Command wire A, one per bridge (async) |
| cmd_b_i | input | NB | Command wire B, one per bridge (async) |
| trip_i | input | NB | Current-trip comparator flag per bridge (async) |
| ocp_i | input | NB | Overcurrent detect flag per bridge (async) |
| uv_i | input | 1 | Undervoltage flag (async) |
| ot_i | input | 1 | Over-temperature flag (async) |
| hi1_o | output | NB | Leg 1 high-side gate enable |
| lo1_o | output | NB | Leg 1 low-side gate enable |
| hi2_o | output | NB | Leg 2 high-side gate enable |
| lo2_o | output | NB | Leg 2 low-side gate enable |
| fault_o | output | NB | Overcurrent fault latch per bridge |
| standby_o | output | 1 | Standby state indicator |
| gdis_o | output | 1 | Global disable (undervoltage or over-temperature) |

## Verification
The assertions check on every cycle that no leg ever has both of its switches on. They also check that a faulted bridge, standby and a global disable each leave the affected gates off, and that a fault latch only ever falls right after standby. The bench scenarios are the only way to show the behaviour that depends on time and order. That covers the lengths of the fast, dead and slow chop phases, the 1 ms idle window and its restart, the wake-up hold, and the decode of all sixteen input combinations of the two bridges. It also covers recovery after the undervoltage and over-temperature flags clear.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        SYS_RUN,
        SYS_SLEEP,
        SYS_WAKE
    } sys_state_t;

    typedef enum logic [2:0] {
        BR_OFF,
        BR_FWD,
        BR_REV,
        BR_BRAKE,
        BR_FAST,
        BR_DEAD,
        BR_SLOW
    } br_state_t;

    // gate pattern order: {hi1, lo1, hi2, lo2}
    localparam logic [3:0] PAT_OFF   = 4'b0000;
    localparam logic [3:0] PAT_FWD   = 4'b1001;
    localparam logic [3:0] PAT_REV   = 4'b0110;
    localparam logic [3:0] PAT_BRAKE = 4'b0101;

    function automatic br_state_t decode_cmd(input logic a, input logic b);
        unique case ({a, b})
            2'b10:   return BR_FWD;
            2'b01:   return BR_REV;
            2'b11:   return BR_BRAKE;
            default: return BR_OFF;
        endcase
    endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/hbd_idle_fsm.sv
module hbd_idle_fsm
    import hbd_pkg::*;
#(
    parameter int IDLE_CYC = 10000,
    parameter int WAKE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_in_i,
    output logic sleep_o,
    output logic hold_o,
    output logic clr_o
);
    localparam int MAXC = (IDLE_CYC > WAKE_CYC) ? IDLE_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    sys_state_t state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SYS_RUN;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SYS_RUN: begin
                if (any_in_i) begin
                    cnt_nx = '0;
                end else if (cnt == CW'(IDLE_CYC - 1)) begin
                    state_nx = SYS_SLEEP;        // idle expired
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            SYS_SLEEP: begin
                if (any_in_i) begin
                    state_nx = SYS_WAKE;         // input seen
                    cnt_nx   = '0;
                end
            end
            SYS_WAKE: begin
                if (cnt == CW'(WAKE_CYC - 1)) begin
                    state_nx = SYS_RUN;          // hold expired
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: begin
                state_nx = SYS_RUN;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        sleep_o = (state == SYS_SLEEP);
        hold_o  = (state != SYS_RUN);
        clr_o   = (state == SYS_SLEEP) && any_in_i;
    end
endmodule

// File: rtl/hbd_bridge.sv
module hbd_bridge
    import hbd_pkg::*;
#(
    parameter int FAST_CYC = 125,
    parameter int DEAD_CYC = 5,
    parameter int SLOW_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_a_i,
    input  logic cmd_b_i,
    input  logic trip_i,
    input  logic ocp_i,
    input  logic kill_i,
    input  logic clr_i,
    output logic hi1_o,
    output logic lo1_o,
    output logic hi2_o,
    output logic lo2_o,
    output logic fault_o
);
    localparam int MAXC = FAST_CYC + DEAD_CYC + SLOW_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    br_state_t     state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          dir_fwd, dir_fwd_nx;
    logic          fault_q;
    logic          same_cmd;
    logic [3:0]    pat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= BR_OFF;
            cnt     <= '0;
            dir_fwd <= 1'b0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            dir_fwd <= dir_fwd_nx;
        end
    end

    // overcurrent latch: a new detection wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fault_q <= 1'b0;
        else if (ocp_i)  fault_q <= 1'b1;
        else if (clr_i)  fault_q <= 1'b0;
    end

    assign same_cmd = dir_fwd ? (cmd_a_i && !cmd_b_i) : (!cmd_a_i && cmd_b_i);

    always_comb begin
        state_nx   = state;
        cnt_nx     = cnt;
        dir_fwd_nx = dir_fwd;
        if (kill_i || fault_q) begin
            state_nx = BR_OFF;                   // kill
            cnt_nx   = '0;
        end else begin
            unique case (state)
                BR_FWD, BR_REV: begin
                    if (trip_i) begin
                        state_nx   = BR_FAST;    // trip
                        cnt_nx     = CW'(FAST_CYC - 1);
                        dir_fwd_nx = (state == BR_FWD);
                    end else begin
                        state_nx = decode_cmd(cmd_a_i, cmd_b_i);
                    end
                end
                BR_FAST: begin
                    if (!same_cmd) begin
                        state_nx = decode_cmd(cmd_a_i, cmd_b_i);   // abort
                    end else if (cnt == '0) begin
                        state_nx = BR_DEAD;      // fast done
                        cnt_nx   = CW'(DEAD_CYC - 1);
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
                BR_DEAD: begin
                    if (!same_cmd) begin
                        state_nx = decode_cmd(cmd_a_i, cmd_b_i);
                    end else if (cnt == '0) begin
                        state_nx = BR_SLOW;      // dead done
                        cnt_nx   = CW'(SLOW_CYC - 1);
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
                BR_SLOW: begin
                    if (!same_cmd || cnt == '0) begin
                        state_nx = decode_cmd(cmd_a_i, cmd_b_i);   // slow done
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
                default: state_nx = decode_cmd(cmd_a_i, cmd_b_i); // decode
            endcase
        end
    end

    always_comb begin
        unique case (state)
            BR_FWD:   pat = PAT_FWD;
            BR_REV:   pat = PAT_REV;
            BR_BRAKE: pat = PAT_BRAKE;
            BR_FAST:  pat = dir_fwd ? PAT_REV : PAT_FWD;
            BR_SLOW:  pat = PAT_BRAKE;
            default:  pat = PAT_OFF;
        endcase
        if (kill_i || fault_q) pat = PAT_OFF;
        {hi1_o, lo1_o, hi2_o, lo2_o} = pat;
        fault_o = fault_q;
    end
endmodule

// File: rtl/hbridge_cmd_dec.sv
module hbridge_cmd_dec #(
    parameter int NB      = 2,
    parameter int CLK_KHZ = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] cmd_a_i,
    input  logic [NB-1:0] cmd_b_i,
    input  logic [NB-1:0] trip_i,
    input  logic [NB-1:0] ocp_i,
    input  logic          uv_i,
    input  logic          ot_i,
    output logic [NB-1:0] hi1_o,
    output logic [NB-1:0] lo1_o,
    output logic [NB-1:0] hi2_o,
    output logic [NB-1:0] lo2_o,
    output logic [NB-1:0] fault_o,
    output logic          standby_o,
    output logic          gdis_o
);
    localparam int IDLE_CYC = CLK_KHZ;                 // 1 ms
    localparam int WAKE_CYC = CLK_KHZ / 5;             // 200 us
    localparam int TOFF_RAW = CLK_KHZ * 25 / 1000;     // 25 us
    localparam int DEAD_RAW = CLK_KHZ / 2000;          // 0.5 us
    localparam int DEAD_CYC = (DEAD_RAW < 1) ? 1 : DEAD_RAW;
    localparam int TOFF_CYC = (TOFF_RAW < DEAD_CYC + 2) ? DEAD_CYC + 2 : TOFF_RAW;
    localparam int FAST_CYC = TOFF_CYC / 2;
    localparam int SLOW_CYC = TOFF_CYC - FAST_CYC - DEAD_CYC;
    localparam int SW       = 4 * NB + 2;

    logic [SW-1:0] raw_in, syn_in;
    logic [NB-1:0] a_s, b_s, trip_s, ocp_s;
    logic          uv_s, ot_s;
    logic          sleep, hold, clr, kill;

    assign raw_in = {cmd_a_i, cmd_b_i, trip_i, ocp_i, uv_i, ot_i};

    hbd_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    assign {a_s, b_s, trip_s, ocp_s, uv_s, ot_s} = syn_in;

    hbd_idle_fsm #(.IDLE_CYC(IDLE_CYC), .WAKE_CYC(WAKE_CYC)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_in_i (|{a_s, b_s}),
        .sleep_o  (sleep),
        .hold_o   (hold),
        .clr_o    (clr)
    );

    assign kill      = hold | uv_s | ot_s;
    assign standby_o = sleep;
    assign gdis_o    = uv_s | ot_s;

    for (genvar i = 0; i < NB; i++) begin : g_br
        hbd_bridge #(
            .FAST_CYC (FAST_CYC),
            .DEAD_CYC (DEAD_CYC),
            .SLOW_CYC (SLOW_CYC)
        ) u_br (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_a_i (a_s[i]),
            .cmd_b_i (b_s[i]),
            .trip_i  (trip_s[i]),
            .ocp_i   (ocp_s[i]),
            .kill_i  (kill),
            .clr_i   (clr),
            .hi1_o   (hi1_o[i]),
            .lo1_o   (lo1_o[i]),
            .hi2_o   (hi2_o[i]),
            .lo2_o   (lo2_o[i]),
            .fault_o (fault_o[i])
        );
    end
endmodule

// File: rtl/hbd_chk.sv
module hbd_chk #(
    parameter int NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB-1:0] hi1_o,
    input logic [NB-1:0] lo1_o,
    input logic [NB-1:0] hi2_o,
    input logic [NB-1:0] lo2_o,
    input logic [NB-1:0] fault_o,
    input logic          standby_o,
    input logic          gdis_o
);
    for (genvar i = 0; i < NB; i++) begin : g_c
        // R10
        leg_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !((hi1_o[i] && lo1_o[i]) || (hi2_o[i] && lo2_o[i])));
        // R7
        fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault_o[i] |-> !(hi1_o[i] || lo1_o[i] || hi2_o[i] || lo2_o[i]));
        // R8
        fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fault_o[i]) |-> $past(standby_o));
    end

    // R4
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> ({hi1_o, lo1_o, hi2_o, lo2_o} == '0));
    // R9
    gdis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gdis_o |-> ({hi1_o, lo1_o, hi2_o, lo2_o} == '0));
endmodule

bind hbridge_cmd_dec hbd_chk #(.NB(NB)) u_hbd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hi1_o     (hi1_o),
    .lo1_o     (lo1_o),
    .hi2_o     (hi2_o),
    .lo2_o     (lo2_o),
    .fault_o   (fault_o),
    .standby_o (standby_o),
    .gdis_o    (gdis_o)
);

// File: tb/test_hbridge_cmd_dec.sv
module test_hbridge_cmd_dec;
    localparam int NB   = 2;
    localparam int KHZ  = 2000;
    localparam int IDLE = 2000;   // 1 ms at 2 MHz
    localparam int WAKE = 400;    // 200 us
    localparam int FAST = 25;     // 50 cycles off time / 2
    localparam int DEAD = 1;
    localparam int SLOW = 24;

    logic clk = 0, rst_n = 0;
    logic [NB-1:0] cmd_a = 0, cmd_b = 0, trip = 0, ocp = 0;
    logic uv = 0, ot = 0;
    logic [NB-1:0] hi1, lo1, hi2, lo2, fault;
    logic standby, gdis;
    int total = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    hbridge_cmd_dec #(.NB(NB), .CLK_KHZ(KHZ)) i_hbridge_cmd_dec (
        .clk(clk), .rst_n(rst_n), .cmd_a_i(cmd_a), .cmd_b_i(cmd_b),
        .trip_i(trip), .ocp_i(ocp), .uv_i(uv), .ot_i(ot),
        .hi1_o(hi1), .lo1_o(lo1), .hi2_o(hi2), .lo2_o(lo2),
        .fault_o(fault), .standby_o(standby), .gdis_o(gdis)
    );

    function automatic logic [3:0] pat(input int b);
        return {hi1[b], lo1[b], hi2[b], lo2[b]};
    endfunction

    function automatic logic [3:0] exp_pat(input logic a, input logic bb);
        if (a && !bb) return 4'b1001;
        if (!a && bb) return 4'b0110;
        if (a && bb)  return 4'b0101;
        return 4'b0000;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chop_test(input int b, input bit fwd);
        int nf = 0, nd = 0, ns = 0;
        logic [3:0] fpat, dpat;
        dpat = fwd ? 4'b1001 : 4'b0110;
        fpat = fwd ? 4'b0110 : 4'b1001;
        cmd_a = 0; cmd_b = 0;
        cmd_a[b] = fwd; cmd_b[b] = !fwd;
        step(8);
        chk(pat(b) == dpat, "R3 drive before trip", pat(b), dpat);
        trip[b] = 1;
        step(2);
        trip[b] = 0;
        for (int k = 0; k < 100; k++) begin
            step(1);
            if (pat(b) == fpat) nf++;
            else if (pat(b) == 4'b0000) nd++;
            else if (pat(b) == 4'b0101) ns++;
        end
        chk(nf == FAST, "R3 fast decay cycles", nf, FAST);
        chk(nd == DEAD, "R3 dead cycles", nd, DEAD);
        chk(ns == SLOW, "R3 slow decay cycles", ns, SLOW);
        chk(pat(b) == dpat, "R3 return to drive", pat(b), dpat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        step(3);
        // R11 reset state
        chk({hi1, lo1, hi2, lo2} == 0, "R11 gates off in reset", {hi1, lo1, hi2, lo2}, 0);
        rst_n = 1;
        step(4);
        chk({hi1, lo1, hi2, lo2} == 0, "R11 gates off after reset", {hi1, lo1, hi2, lo2}, 0);
        chk(fault == 0, "R11 no fault", fault, 0);
        chk(standby == 0, "R11 no standby", standby, 0);

        // R1 R2 exhaustive sweep over both bridges
        for (int c = 1; c < 16; c++) begin
            cmd_a[0] = c[0]; cmd_b[0] = c[1]; cmd_a[1] = c[2]; cmd_b[1] = c[3];
            step(6);
            for (int b = 0; b < NB; b++)
                chk(pat(b) == exp_pat(cmd_a[b], cmd_b[b]), "R1 R2 decode",
                    pat(b), exp_pat(cmd_a[b], cmd_b[b]));
        end
        cmd_a = 2'b01; cmd_b = 0;
        step(6);
        chk(pat(1) == 0, "R2 coast bridge", pat(1), 0);

        // R3 chop, both directions, both bridges
        chop_test(0, 1);
        chop_test(0, 0);
        chop_test(1, 1);
        chop_test(1, 0);

        // R9 undervoltage and over-temperature
        cmd_a = 2'b11; cmd_b = 2'b00;
        step(6);
        uv = 1; step(6);
        chk({hi1, lo1, hi2, lo2} == 0, "R9 uv gates off", {hi1, lo1, hi2, lo2}, 0);
        chk(gdis == 1, "R9 uv gdis", gdis, 1);
        uv = 0; step(6);
        chk(pat(0) == 4'b1001 && pat(1) == 4'b1001, "R9 uv recovery", pat(0), 9);
        ot = 1; step(6);
        chk({hi1, lo1, hi2, lo2} == 0, "R9 ot gates off", {hi1, lo1, hi2, lo2}, 0);
        chk(gdis == 1, "R9 ot gdis", gdis, 1);
        ot = 0; step(6);
        chk(pat(0) == 4'b1001 && gdis == 0, "R9 ot recovery", pat(0), 9);

        // R7 fault latch per bridge
        cmd_a = 2'b01; cmd_b = 2'b10;
        step(6);
        ocp[0] = 1; step(2); ocp[0] = 0;
        step(6);
        chk(fault == 2'b01, "R7 fault bridge 0 only", fault, 1);
        chk(pat(0) == 0, "R7 faulted bridge off", pat(0), 0);
        chk(pat(1) == 4'b0110, "R7 other bridge runs", pat(1), 6);
        // R8 survives command change
        cmd_a = 2'b00; cmd_b = 2'b11;
        step(50);
        chk(fault == 2'b01 && pat(0) == 0, "R8 fault held after command change", fault, 1);
        ocp[1] = 1; step(2); ocp[1] = 0;
        step(6);
        chk(fault == 2'b11, "R7 fault bridge 1", fault, 3);

        // R5 restart of idle timer
        cmd_a = 0; cmd_b = 0;
        step(IDLE - 50);
        cmd_b[1] = 1; step(2); cmd_b[1] = 0;
        step(IDLE - 50);
        chk(standby == 0, "R5 timer restarted", standby, 0);
        step(100);
        chk(standby == 1, "R4 standby reached", standby, 1);
        chk(fault == 2'b11, "R8 fault held in standby", fault, 3);

        // R6 wake-up hold and R8 clear
        cmd_a[0] = 1;
        step(6);
        chk(standby == 0, "R6 standby left", standby, 0);
        chk(fault == 0, "R8 fault cleared on wake", fault, 0);
        chk(pat(0) == 0, "R6 gates held early", pat(0), 0);
        step(WAKE - 20);
        chk(pat(0) == 0, "R6 gates held late", pat(0), 0);
        step(24);
        chk(pat(0) == 4'b1001, "R6 drive after hold", pat(0), 9);

        // R4 entry timing window
        begin
            int first = -1;
            cmd_a = 0; cmd_b = 0;
            for (int k = 1; k <= IDLE + 10; k++) begin
                step(1);
                if (standby && first < 0) first = k;
            end
            chk(first >= IDLE && first <= IDLE + 4, "R4 entry time", first, IDLE + 2);
        end

        // R8 reset clears fault
        cmd_a = 2'b01;
        step(WAKE + 10);
        ocp[0] = 1; step(2); ocp[0] = 0; step(6);
        chk(fault == 2'b01, "R8 fault set before reset", fault, 1);
        rst_n = 0; step(2); rst_n = 1; step(4);
        chk(fault == 0, "R8 reset clears fault", fault, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule